// File: doc/BRIEF.md
# Chained Interval Timer Pair

Two 16-bit down-counting interval timers, A and B, sit behind a small byte-wide register interface. Each timer has a 16-bit reload latch, a visible counter and a control byte. The control byte holds a run bit, a one-shot bit, a force-load strobe and, for timer B only, a count-source select. Timer A always decrements once per bus cycle. Timer B decrements either once per bus cycle or once per timer A underflow, so the pair can be chained into a 32-bit interval.

When a running counter is at zero in a cycle where it may decrement, it underflows. It reloads from its latch and raises a one-cycle underflow pulse for an external interrupt unit in the following cycle. In one-shot mode the run bit also clears itself. Because timer B counts the registered timer A underflow pulse, a chained B underflow appears exactly one cycle after the A pulse that caused it. Reads are combinational and return the counter stage that holds the settled value. The decrement is computed between that stage and the next clock edge.

Top module: `tmr_pair`

## Requirements
- R1: After reset both latches and both counters hold 0xFFFF, both control bytes read 0x00, and both underflow outputs are low.
- R2: Register offsets are 0/1 for timer A latch low/high, 2/3 for timer B latch low/high, 4 for A control and 5 for B control. A low-byte write changes only the latch. A high-byte write to a stopped timer also loads the whole latch into its counter by the next cycle.
- R3: A high-byte write to a running timer updates the latch only, and the counter keeps decrementing from its current value.
- R4: Control bit 0 is the run bit. A counter reads unchanged in the cycle after run is set and decrements from the cycle after that.
- R5: A counter that is running and counts bus cycles reads one less each cycle. A stopped counter holds its value.
- R6: A counter that is zero in a cycle where it decrements reads its latch value in the next cycle, and its underflow output is high for exactly that cycle.
- R7: With control bit 3 clear the timer keeps running after underflow. With bit 3 set, the run bit reads 0 from the cycle of the underflow pulse, and the counter then holds the reloaded value.
- R8: Writing control bit 4 as 1 copies the latch into the counter by the next cycle. Bit 4 always reads back as 0.
- R9: With timer B control bit 5 set, timer B decrements only in cycles where the timer A underflow output is high. Bit 5 has no effect on timer A and reads as 0 there.
- R10: A chained timer B underflow pulse appears one cycle after the timer A underflow pulse that caused it.
- R11: With a zero latch and run set, the underflow output stays high in every cycle while the timer runs.
- R12: Offsets 6 and 7 read as 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus cycle clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register offset |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i, combinational |
| ta_uf_o | output | 1 | Timer A underflow pulse |
| tb_uf_o | output | 1 | Timer B underflow pulse |

## Verification
The hardest case to reach is a chained timer B underflow, because it needs timer B at zero in exactly the cycle when a timer A pulse arrives. The stimulus gives B a latch of one and A a latch of two. Two A intervals then step B to zero and through its underflow within a few cycles. B's count and both pulses are sampled every cycle, so the bench shows that B holds its value between A pulses and that its pulse lags A's by one cycle. The zero-latch run covers the other awkward case, where a reload and an underflow happen in every cycle.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  parameter int CNT_W  = 16;
  parameter int BUS_W  = 8;
  parameter int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_LO  = 3'd0;
  localparam logic [ADDR_W-1:0] A_HI  = 3'd1;
  localparam logic [ADDR_W-1:0] B_LO  = 3'd2;
  localparam logic [ADDR_W-1:0] B_HI  = 3'd3;
  localparam logic [ADDR_W-1:0] A_CTL = 3'd4;
  localparam logic [ADDR_W-1:0] B_CTL = 3'd5;

  localparam int CTL_RUN  = 0;
  localparam int CTL_ONE  = 3;
  localparam int CTL_LOAD = 4;
  localparam int CTL_SRC  = 5;
endpackage

// File: rtl/tmr_unit.sv
module tmr_unit
  import tmr_pkg::*;
#(
  parameter int W     = CNT_W,
  parameter bit CHAIN = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_lo_i,
  input  logic             wr_hi_i,
  input  logic             wr_ctl_i,
  input  logic [BUS_W-1:0] wdata_i,
  input  logic             tick_i,
  output logic [W-1:0]     cnt_o,
  output logic [W-1:0]     lat_o,
  output logic [BUS_W-1:0] ctl_o,
  output logic             uf_o
);
  localparam int LW = BUS_W;
  localparam int HW = W - LW;

  logic [W-1:0] lat_q, cnt_q, cnt_d;
  logic         run_q, one_q, src_q, src_d, uf_q;
  logic         dec_en, uf_now, force_ld;

  generate
    if (CHAIN) begin : g_src
      assign src_d = wdata_i[CTL_SRC];
    end else begin : g_nosrc
      assign src_d = 1'b0;
    end
  endgenerate

  assign dec_en   = run_q & (src_q ? tick_i : 1'b1);
  assign uf_now   = dec_en & (cnt_q == '0);
  assign force_ld = wr_ctl_i & wdata_i[CTL_LOAD];

  // priority: forced load, stopped high-byte load, reload, decrement
  always_comb begin
    cnt_d = cnt_q;
    if (force_ld)               cnt_d = lat_q;
    else if (wr_hi_i && !run_q) cnt_d = {wdata_i[HW-1:0], lat_q[LW-1:0]};
    else if (uf_now)            cnt_d = lat_q;
    else if (dec_en)            cnt_d = cnt_q - W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lat_q <= '1;
      cnt_q <= '1;
      run_q <= 1'b0;
      one_q <= 1'b0;
      src_q <= 1'b0;
      uf_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      uf_q  <= uf_now;
      if (wr_lo_i) lat_q[LW-1:0] <= wdata_i;
      if (wr_hi_i) lat_q[W-1:LW] <= wdata_i[HW-1:0];
      if (wr_ctl_i) begin
        run_q <= wdata_i[CTL_RUN];
        one_q <= wdata_i[CTL_ONE];
        src_q <= src_d;
      end else if (uf_now && one_q) begin
        run_q <= 1'b0;
      end
    end
  end

  always_comb begin
    ctl_o          = '0;
    ctl_o[CTL_RUN] = run_q;
    ctl_o[CTL_ONE] = one_q;
    ctl_o[CTL_SRC] = src_q;
  end

  assign cnt_o = cnt_q;
  assign lat_o = lat_q;
  assign uf_o  = uf_q;
endmodule

// File: rtl/tmr_rd_mux.sv
module tmr_rd_mux
  import tmr_pkg::*;
#(
  parameter int W = CNT_W
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [W-1:0]      a_cnt_i,
  input  logic [W-1:0]      b_cnt_i,
  input  logic [BUS_W-1:0]  a_ctl_i,
  input  logic [BUS_W-1:0]  b_ctl_i,
  output logic [BUS_W-1:0]  rdata_o
);
  localparam int LW = BUS_W;

  always_comb begin
    unique case (addr_i)
      A_LO:    rdata_o = a_cnt_i[LW-1:0];
      A_HI:    rdata_o = BUS_W'(a_cnt_i[W-1:LW]);
      B_LO:    rdata_o = b_cnt_i[LW-1:0];
      B_HI:    rdata_o = BUS_W'(b_cnt_i[W-1:LW]);
      A_CTL:   rdata_o = a_ctl_i;
      B_CTL:   rdata_o = b_ctl_i;
      default: rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/tmr_pair.sv
module tmr_pair
  import tmr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BUS_W-1:0]  wdata_i,
  output logic [BUS_W-1:0]  rdata_o,
  output logic              ta_uf_o,
  output logic              tb_uf_o
);
  logic [CNT_W-1:0] a_cnt, b_cnt, a_lat, b_lat;
  logic [BUS_W-1:0] a_ctl, b_ctl;
  logic             a_uf, b_uf;

  tmr_unit #(.W(CNT_W), .CHAIN(1'b0)) i_tmr_a (
    .clk_i, .rst_ni,
    .wr_lo_i (we_i && addr_i == A_LO),
    .wr_hi_i (we_i && addr_i == A_HI),
    .wr_ctl_i(we_i && addr_i == A_CTL),
    .wdata_i,
    .tick_i  (1'b0),
    .cnt_o   (a_cnt),
    .lat_o   (a_lat),
    .ctl_o   (a_ctl),
    .uf_o    (a_uf)
  );

  tmr_unit #(.W(CNT_W), .CHAIN(1'b1)) i_tmr_b (
    .clk_i, .rst_ni,
    .wr_lo_i (we_i && addr_i == B_LO),
    .wr_hi_i (we_i && addr_i == B_HI),
    .wr_ctl_i(we_i && addr_i == B_CTL),
    .wdata_i,
    .tick_i  (a_uf),
    .cnt_o   (b_cnt),
    .lat_o   (b_lat),
    .ctl_o   (b_ctl),
    .uf_o    (b_uf)
  );

  tmr_rd_mux #(.W(CNT_W)) i_rd_mux (
    .addr_i,
    .a_cnt_i(a_cnt),
    .b_cnt_i(b_cnt),
    .a_ctl_i(a_ctl),
    .b_ctl_i(b_ctl),
    .rdata_o
  );

  assign ta_uf_o = a_uf;
  assign tb_uf_o = b_uf;
endmodule

// File: rtl/tmr_pair_chk.sv
module tmr_pair_chk
  import tmr_pkg::*;
#(
  parameter int W = CNT_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [W-1:0]      a_cnt,
  input logic [W-1:0]      a_lat,
  input logic [BUS_W-1:0]  a_ctl,
  input logic [BUS_W-1:0]  b_ctl,
  input logic              a_uf,
  input logic              b_uf
);
  logic wr_a;
  assign wr_a = we_i && (addr_i == A_LO || addr_i == A_HI || addr_i == A_CTL);

  // R6
  reload_on_uf_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    a_uf && !$past(wr_a) |-> a_cnt == a_lat);

  // R7
  one_shot_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    a_uf && $past(a_ctl[CTL_ONE]) && !$past(wr_a) |-> !a_ctl[CTL_RUN]);

  // R5
  step_by_one_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(a_ctl[CTL_RUN]) && !$past(wr_a) && !a_uf |-> a_cnt == $past(a_cnt) - W'(1));

  // R5
  hold_stopped_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(a_ctl[CTL_RUN]) && !$past(wr_a) |-> $stable(a_cnt));

  // R4
  uf_needs_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    a_uf |-> $past(a_ctl[CTL_RUN]));

  // R10
  chain_lag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    b_uf && $past(b_ctl[CTL_SRC]) |-> $past(a_uf));
endmodule

bind tmr_pair tmr_pair_chk #(.W(tmr_pkg::CNT_W)) i_chk (
  .clk_i (clk_i),
  .rst_ni(rst_ni),
  .we_i  (we_i),
  .addr_i(addr_i),
  .a_cnt (a_cnt),
  .a_lat (a_lat),
  .a_ctl (a_ctl),
  .b_ctl (b_ctl),
  .a_uf  (a_uf),
  .b_uf  (b_uf)
);

// File: tb/test_tmr_pair.sv
module test_tmr_pair;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       we = 1'b0;
  logic [2:0] addr = 3'd0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;
  logic       ta_uf, tb_uf;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  typedef struct {
    string      req;
    logic [2:0] addr;
    logic [7:0] exp;
    bit         chk_uf;
    logic       ea;
    logic       eb;
  } item_t;

  item_t q[$];

  always #2 clk = ~clk;

  tmr_pair i_tmr_pair (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .ta_uf_o(ta_uf), .tb_uf_o(tb_uf)
  );

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
  endtask

  task automatic obs(input string req, input logic [2:0] a, input logic [7:0] e,
                     input bit cu = 1'b0, input logic ea = 1'b0, input logic eb = 1'b0);
    item_t it;
    @(negedge clk);
    we = 1'b0; addr = a;
    it.req = req; it.addr = a; it.exp = e; it.chk_uf = cu; it.ea = ea; it.eb = eb;
    q.push_back(it);
  endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        n_chk++;
        if (rdata !== it.exp) begin
          n_err++;
          $display("FAIL %s addr %0d rdata %02h expected %02h", it.req, it.addr, rdata, it.exp);
        end
        if (it.chk_uf) begin
          n_chk++;
          if (ta_uf !== it.ea || tb_uf !== it.eb) begin
            n_err++;
            $display("FAIL %s underflow a/b %b%b expected %b%b", it.req, ta_uf, tb_uf, it.ea, it.eb);
          end
        end
      end
    end
  end

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state, R12 unused offsets
        obs("R1", 3'd0, 8'hFF, 1, 0, 0);
        obs("R1", 3'd1, 8'hFF);
        obs("R1", 3'd3, 8'hFF);
        obs("R1", 3'd4, 8'h00, 1, 0, 0);
        obs("R1", 3'd5, 8'h00);
        obs("R12", 3'd6, 8'h00);
        obs("R12", 3'd7, 8'h00);
        // R2 stopped high write loads counter
        wr(3'd0, 8'h05);
        wr(3'd1, 8'h00);
        obs("R2", 3'd0, 8'h05);
        obs("R2", 3'd1, 8'h00);
        wr(3'd0, 8'h03);
        obs("R2", 3'd0, 8'h05);
        // R8 force load
        wr(3'd4, 8'h10);
        obs("R8", 3'd0, 8'h03);
        obs("R8", 3'd4, 8'h00);
        // R4/R5/R6/R7 continuous run, latch 3
        wr(3'd4, 8'h01);
        obs("R4", 3'd0, 8'h03, 1, 0, 0);
        obs("R5", 3'd0, 8'h02);
        obs("R5", 3'd0, 8'h01);
        obs("R5", 3'd0, 8'h00, 1, 0, 0);
        obs("R6", 3'd0, 8'h03, 1, 1, 0);
        obs("R7", 3'd4, 8'h01, 1, 0, 0);
        wr(3'd4, 8'h00);
        obs("R5", 3'd0, 8'h00, 1, 0, 0);
        obs("R5", 3'd0, 8'h00);
        // R7 one-shot
        wr(3'd4, 8'h09);
        obs("R7", 3'd0, 8'h00, 1, 0, 0);
        obs("R7", 3'd4, 8'h08, 1, 1, 0);
        obs("R7", 3'd0, 8'h03, 1, 0, 0);
        obs("R7", 3'd0, 8'h03);
        // R3 high write while running
        wr(3'd4, 8'h01);
        wr(3'd1, 8'h01);
        obs("R3", 3'd0, 8'h02);
        obs("R3", 3'd1, 8'h00);
        obs("R3", 3'd0, 8'h00);
        obs("R3", 3'd1, 8'h01, 1, 1, 0);
        wr(3'd4, 8'h00);
        obs("R3", 3'd0, 8'h01);
        // R11 zero latch
        wr(3'd0, 8'h00);
        wr(3'd1, 8'h00);
        wr(3'd4, 8'h01);
        obs("R11", 3'd0, 8'h00, 1, 0, 0);
        obs("R11", 3'd0, 8'h00, 1, 1, 0);
        obs("R11", 3'd0, 8'h00, 1, 1, 0);
        obs("R11", 3'd0, 8'h00, 1, 1, 0);
        wr(3'd4, 8'h00);
        obs("R11", 3'd0, 8'h00, 1, 1, 0);
        obs("R11", 3'd0, 8'h00, 1, 0, 0);
        // R9/R10 chaining
        wr(3'd0, 8'h02);
        wr(3'd1, 8'h00);
        wr(3'd2, 8'h01);
        wr(3'd3, 8'h00);
        wr(3'd5, 8'h21);
        obs("R9", 3'd5, 8'h21, 1, 0, 0);
        wr(3'd4, 8'h21);
        obs("R9", 3'd4, 8'h01, 1, 0, 0);
        obs("R9", 3'd2, 8'h01, 1, 0, 0);
        obs("R9", 3'd2, 8'h01, 1, 0, 0);
        obs("R9", 3'd2, 8'h01, 1, 1, 0);
        obs("R9", 3'd2, 8'h00, 1, 0, 0);
        obs("R9", 3'd2, 8'h00, 1, 0, 0);
        obs("R10", 3'd2, 8'h00, 1, 1, 0);
        obs("R10", 3'd2, 8'h01, 1, 0, 1);
        obs("R10", 3'd3, 8'h00, 1, 0, 0);
        repeat (3) @(negedge clk);
        done = 1'b1;
      end
      begin
        repeat (5000) @(posedge clk);
        if (!done) begin
          n_chk++;
          n_err++;
          $display("FAIL watchdog expired");
        end
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule